// File: doc/BRIEF.md
# Posted Memory Write Target Acceptor

This block is the receiving half of a bus bridge port. It watches a PCI-style initiator bus, recognises memory write bursts aimed at the far side of the bridge, claims them, and stores the address and every data DWORD in a built-in posted-write FIFO. The initiator therefore finishes without waiting for the far bus. A separate forwarding engine, outside this block, drains the FIFO through a simple read port.

Only the two posted memory write commands are claimed. Every other command, and every cycle that misses the bridge window, is left alone. Once the block has claimed a burst it accepts one DWORD on every clock. It ends the burst early, with a disconnect that still carries data, when the next DWORD would cross an internal address boundary or when the FIFO is about to be full. After the final data phase it drives its three target signals high for one clock, then releases them.

Top module: `pci_posted_wr_target`

## Requirements
- R1: An access is claimed only when `hit` is high during the address phase, the command on `cbe_n` is 4'b0111 (memory write) or 4'b1111 (memory write and invalidate), and at least two FIFO entries are free. Any other access never sees `devsel_n` low and never drives `tgt_oe`.
- R2: For a claimed access, `devsel_n` goes low on the second clock after the address phase (medium timing), and `trdy_n` goes low one clock after that.
- R3: A data DWORD moves into the FIFO only on a clock where `irdy_n` and `trdy_n` are both low. Once `trdy_n` is low, it stays low on every clock until the final phase, so no target wait states are inserted.
- R4: The first FIFO entry of a claimed burst is the address entry: tag 0, last 0, the `be` field holding the raw command, and the data field holding the full address.
- R5: Each data entry has tag 1, byte enables equal to `~cbe_n`, and data equal to `ad`. Its last flag is 1 only on the final data phase.
- R6: For memory write and invalidate, `stop_n` is low together with `trdy_n` on the data phase whose DWORD address modulo `CLINE_DW` equals `CLINE_DW-1`.
- R7: For memory write, `stop_n` is low together with `trdy_n` on the data phase whose DWORD address modulo 1024 equals 1023 (the last DWORD before an aligned 4KB boundary).
- R8: `stop_n` is low on the data phase that would take the FIFO to `DEPTH` entries. The FIFO never overflows.
- R9: The final phase is a transfer with `frame_n` high, or `irdy_n` and `stop_n` both low. On the next clock `devsel_n`, `trdy_n` and `stop_n` are all high with `tgt_oe` high. One clock later `tgt_oe` is low.
- R10: Once `stop_n` is low, it stays low until the final phase completes, even through clocks where the initiator holds `irdy_n` high.
- R11: `rd_valid` is high while the FIFO holds entries. Each clock with `rd_en` high removes the head entry, and entries leave in the order they were written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low reset |
| frame_n | input | 1 | Initiator cycle frame, active low |
| irdy_n | input | 1 | Initiator ready, active low |
| ad | input | 32 | Address in the address phase, data in data phases |
| cbe_n | input | 4 | Command in the address phase, active-low byte enables in data phases |
| hit | input | 1 | Address falls in the bridge's forwarding window |
| devsel_n | output | 1 | Target device select, active low |
| trdy_n | output | 1 | Target ready, active low |
| stop_n | output | 1 | Target stop request, active low |
| tgt_oe | output | 1 | Target drives devsel_n, trdy_n and stop_n |
| rd_en | input | 1 | Pop the FIFO head entry |
| rd_valid | output | 1 | FIFO head entry is valid |
| rd_tag | output | 1 | Head entry kind: 0 address, 1 data |
| rd_last | output | 1 | Head entry is the final data of its burst |
| rd_be | output | 4 | Command (address entry) or active-high byte enables |
| rd_data | output | 32 | Address or data of the head entry |

## Verification
A state machine stuck in or skipping a phase shows on the handshake pins within one clock. A late or early `devsel_n`/`trdy_n`, a missing turnaround, or `tgt_oe` left on is visible at the negative edge after the faulty transition. A wrong running DWORD address or FIFO count does not show until the phase where the bench predicts a disconnect: `stop_n` then appears one phase too early or too late, and that shifts the last flag and the entry count seen when the FIFO is drained right after the burst. Corrupted FIFO fields or pointers show as mismatched tag, byte enables or data on the first pop that reads them.

// File: rtl/pci_posted_wr_target.sv
module pci_posted_wr_target #(
  parameter int DEPTH    = 8,
  parameter int CLINE_DW = 8,
  parameter int PAGE_DW  = 1024
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        frame_n,
  input  logic        irdy_n,
  input  logic [31:0] ad,
  input  logic [3:0]  cbe_n,
  input  logic        hit,
  output logic        devsel_n,
  output logic        trdy_n,
  output logic        stop_n,
  output logic        tgt_oe,
  input  logic        rd_en,
  output logic        rd_valid,
  output logic        rd_tag,
  output logic        rd_last,
  output logic [3:0]  rd_be,
  output logic [31:0] rd_data
);
  localparam int AW  = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW  = $clog2(DEPTH + 1);
  localparam int CLW = $clog2(CLINE_DW);
  localparam int PGW = $clog2(PAGE_DW);
  localparam int EW  = 38;

  typedef enum logic [2:0] {S_IDLE, S_DEC, S_CLAIM, S_DATA, S_TURN, S_SKIP} st_t;
  st_t state;

  logic [29:0]   cur;
  logic          mwi, stop_hold;
  logic [CW-1:0] count;
  logic [AW-1:0] wptr, rptr;
  logic [EW-1:0] mem [DEPTH];

  wire cmd_ok = (cbe_n == 4'b0111) || (cbe_n == 4'b1111);
  wire claim  = (state == S_IDLE) && !frame_n && hit && cmd_ok && (count <= CW'(DEPTH - 2));
  wire in_dat = (state == S_DATA);
  wire xfer   = in_dat && !irdy_n;
  wire bound  = mwi ? (cur[CLW-1:0] == CLW'(CLINE_DW - 1)) : (cur[PGW-1:0] == PGW'(PAGE_DW - 1));
  wire fill   = (count >= CW'(DEPTH - 1));
  wire stop_now = in_dat && (bound || fill || stop_hold);
  wire last   = xfer && (frame_n || stop_now);
  wire wr_en  = claim || xfer;
  wire rd_ok  = rd_en && (count != '0);
  wire [EW-1:0] wr_ent = claim ? {1'b0, 1'b0, cbe_n, ad} : {1'b1, last, ~cbe_n, ad};

  assign devsel_n = !((state == S_CLAIM) || in_dat);
  assign trdy_n   = !in_dat;
  assign stop_n   = !stop_now;
  assign tgt_oe   = (state == S_CLAIM) || in_dat || (state == S_TURN);
  assign rd_valid = (count != '0);
  assign {rd_tag, rd_last, rd_be, rd_data} = mem[rptr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      cur       <= '0;
      mwi       <= 1'b0;
      stop_hold <= 1'b0;
    end else begin
      case (state)
        S_IDLE:  if (claim) state <= S_DEC;
                 else if (!frame_n) state <= S_SKIP;
        S_DEC:   state <= S_CLAIM;
        S_CLAIM: state <= S_DATA;
        S_DATA:  if (last) state <= S_TURN;
        S_TURN:  state <= S_IDLE;
        S_SKIP:  if (frame_n && irdy_n) state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
      if (claim) begin
        cur <= ad[31:2];
        mwi <= cbe_n[3];
      end else if (xfer) begin
        cur <= cur + 30'd1;
      end
      stop_hold <= stop_now && !last;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count <= '0;
      wptr  <= '0;
      rptr  <= '0;
    end else begin
      if (wr_en) wptr <= (wptr == AW'(DEPTH - 1)) ? '0 : wptr + AW'(1);
      if (rd_ok) rptr <= (rptr == AW'(DEPTH - 1)) ? '0 : rptr + AW'(1);
      count <= count + CW'(wr_en) - CW'(rd_ok);
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) mem[wptr] <= wr_ent;
  end

  assert_trdy_with_devsel_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !trdy_n |-> !devsel_n);
  assert_trdy_after_devsel_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(devsel_n) |=> !trdy_n);
  assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !rd_ok) |-> (count != CW'(DEPTH)));
  assert_stop_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!stop_n && irdy_n) |=> !stop_n);
  assert_turnaround_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!trdy_n && !irdy_n && (frame_n || !stop_n)) |=> (tgt_oe && devsel_n && trdy_n && stop_n));
  assert_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(devsel_n) |=> !tgt_oe);
  assert_no_wait_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!trdy_n && !(!irdy_n && (frame_n || !stop_n))) |=> !trdy_n);
endmodule

// File: tb/pci_posted_wr_target_bench.sv
module pci_posted_wr_target_bench;
  localparam int DEPTH = 8;
  localparam int CL    = 8;
  localparam int NV    = 13;
  // {drain, hit, cmd[3:0], wait_idx[7:0], nwords[7:0], addr[31:0]}
  localparam logic [53:0] VEC [NV] = '{
    {1'b1, 1'b1, 4'h7, 8'hFF, 8'd3,  32'h0000_0100},
    {1'b1, 1'b1, 4'hF, 8'hFF, 8'd5,  32'h0000_1018},
    {1'b1, 1'b1, 4'h7, 8'hFF, 8'd5,  32'h0000_0FF8},
    {1'b1, 1'b1, 4'h7, 8'hFF, 8'd10, 32'h0000_2000},
    {1'b1, 1'b1, 4'h3, 8'hFF, 8'd2,  32'h0000_0200},
    {1'b1, 1'b0, 4'h7, 8'hFF, 8'd2,  32'h0000_0200},
    {1'b1, 1'b1, 4'h7, 8'd1,  8'd4,  32'h0000_0300},
    {1'b0, 1'b1, 4'h7, 8'hFF, 8'd6,  32'h0000_0400},
    {1'b1, 1'b1, 4'h7, 8'hFF, 8'd2,  32'h0000_0500},
    {1'b1, 1'b1, 4'hF, 8'd0,  8'd3,  32'h0000_001C},
    {1'b1, 1'b1, 4'h7, 8'hFF, 8'd1,  32'h0000_0600},
    {1'b1, 1'b1, 4'hF, 8'hFF, 8'd4,  32'h0000_0040},
    {1'b1, 1'b1, 4'hB, 8'hFF, 8'd2,  32'h0000_0700}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic frame_n = 1'b1, irdy_n = 1'b1, hit = 1'b0, rd_en = 1'b0;
  logic [31:0] ad = '0;
  logic [3:0]  cbe_n = 4'hF;
  logic devsel_n, trdy_n, stop_n, tgt_oe, rd_valid, rd_tag, rd_last;
  logic [3:0]  rd_be;
  logic [31:0] rd_data;

  int total = 0, bad = 0, cnt = 0, qh = 0, qt = 0;
  logic [37:0] q [64];

  always #2.5 clk = ~clk;

  pci_posted_wr_target #(.DEPTH(DEPTH), .CLINE_DW(CL), .PAGE_DW(1024)) u_pci_posted_wr_target (
    .clk(clk), .rst_n(rst_n), .frame_n(frame_n), .irdy_n(irdy_n), .ad(ad), .cbe_n(cbe_n),
    .hit(hit), .devsel_n(devsel_n), .trdy_n(trdy_n), .stop_n(stop_n), .tgt_oe(tgt_oe),
    .rd_en(rd_en), .rd_valid(rd_valid), .rd_tag(rd_tag), .rd_last(rd_last), .rd_be(rd_be),
    .rd_data(rd_data));

  task automatic chk(input logic ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic push_exp(input logic [37:0] e);
    q[qt % 64] = e;
    qt++;
    cnt++;
  endtask

  task automatic drain();
    while (qh != qt) begin
      chk(rd_valid === 1'b1, "R11 valid", {63'd0, rd_valid}, 64'd1);
      chk({rd_tag, rd_last, rd_be, rd_data} === q[qh % 64], "R4/R5 entry",
          {26'd0, rd_tag, rd_last, rd_be, rd_data}, {26'd0, q[qh % 64]});
      qh++;
      rd_en = 1'b1;
      @(negedge clk);
    end
    rd_en = 1'b0;
    cnt = 0;
    chk(rd_valid === 1'b0, "R11 empty", {63'd0, rd_valid}, 64'd0);
  endtask

  task automatic run_burst(input logic [53:0] v);
    logic [31:0] addr = v[31:0];
    int n = int'(v[39:32]);
    int widx = int'(v[47:40]);
    logic [3:0] cmd = v[51:48];
    logic h = v[52];
    logic mwi = (cmd == 4'hF);
    logic claim = h && (cmd == 4'h7 || cmd == 4'hF) && (DEPTH - cnt >= 2);
    logic [29:0] a = addr[31:2];
    logic stop_seen = 1'b0, waited = 1'b0, ended = 1'b0, lst, es;
    int done = 0;
    frame_n = 1'b0; irdy_n = 1'b1; ad = addr; cbe_n = cmd; hit = h;
    @(negedge clk);
    hit = 1'b0;
    if (!claim) begin
      for (int k = 1; k <= 4; k++) begin
        chk(devsel_n === 1'b1 && tgt_oe === 1'b0, "R1 not claimed", {62'd0, devsel_n, tgt_oe}, 64'h2);
        irdy_n = 1'b0; frame_n = (k == 4); ad = 32'hA5A5_0000; cbe_n = 4'h0;
        @(negedge clk);
      end
      frame_n = 1'b1; irdy_n = 1'b1;
      @(negedge clk);
      chk(tgt_oe === 1'b0, "R1 never driven", {63'd0, tgt_oe}, 64'd0);
      @(negedge clk);
      return;
    end
    push_exp({1'b0, 1'b0, cmd, addr});
    chk(devsel_n === 1'b1 && tgt_oe === 1'b0, "R2 no fast decode", {62'd0, devsel_n, tgt_oe}, 64'h2);
    irdy_n = 1'b0; frame_n = (n == 1); ad = 32'hD000_0000 + 32'(a); cbe_n = 4'h5;
    @(negedge clk);
    chk(devsel_n === 1'b0 && trdy_n === 1'b1 && tgt_oe === 1'b1, "R2 medium devsel",
        {61'd0, devsel_n, trdy_n, tgt_oe}, 64'h3);
    @(negedge clk);
    while (!ended) begin
      es = stop_seen || (mwi && (a % CL == CL - 1)) || (!mwi && (a % 1024 == 1023)) || (cnt >= DEPTH - 1);
      chk(devsel_n === 1'b0 && trdy_n === 1'b0, "R3 trdy held", {62'd0, devsel_n, trdy_n}, 64'd0);
      chk(stop_n === !es, mwi ? "R6/R8/R10 stop" : "R7/R8/R10 stop", {63'd0, stop_n}, {63'd0, !es});
      if (es) stop_seen = 1'b1;
      lst = stop_seen || (done == n - 1);
      frame_n = lst;
      if (widx == done && !waited) begin
        waited = 1'b1;
        irdy_n = 1'b1;
      end else begin
        irdy_n = 1'b0;
        ad = 32'hD000_0000 + 32'(a);
        cbe_n = 4'(done) ^ 4'h5;
        push_exp({1'b1, lst, ~cbe_n, ad});
        done++;
        a++;
        ended = lst;
      end
      @(negedge clk);
    end
    chk(tgt_oe && devsel_n && trdy_n && stop_n, "R9 turnaround",
        {60'd0, tgt_oe, devsel_n, trdy_n, stop_n}, 64'hF);
    irdy_n = 1'b1; frame_n = 1'b1;
    @(negedge clk);
    chk(tgt_oe === 1'b0, "R9 release", {63'd0, tgt_oe}, 64'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog act=hang exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(devsel_n && trdy_n && stop_n && !tgt_oe && !rd_valid, "R9/R11 reset",
        {59'd0, devsel_n, trdy_n, stop_n, tgt_oe, rd_valid}, 64'h1C);
    rst_n = 1'b1;
    @(negedge clk);
    for (int i = 0; i < NV; i++) begin
      run_burst(VEC[i]);
      if (VEC[i][53]) drain();
    end
    // R11: pop on empty FIFO has no effect
    rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    chk(rd_valid === 1'b0, "R11 empty pop", {63'd0, rd_valid}, 64'd0);
    // R1: exactly two free entries still claims
    run_burst({1'b0, 1'b1, 4'h7, 8'hFF, 8'd5, 32'h0000_0800});
    run_burst({1'b0, 1'b1, 4'h7, 8'hFF, 8'd1, 32'h0000_0900});
    drain();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule